// File: doc/BRIEF.md
# Strobe-Registered CAM Host Interface

This block is the host-side front end of a content-addressable lookup device. A host drives a 32-bit data path, a command/address bus and a single active-low strobe. The strobe frames every cycle. While it is high the block is idle and its data outputs are not enabled. The first clock edge that sees the strobe low is treated as its falling edge. At that edge the block captures every qualifier: write direction, both chip selects, the address/control mode pin, the command/address bus, the half-select pin, the validity pin and the write data. It then uses only those captured values for the rest of the cycle.

Behind the interface sit a 32-entry array of 64-bit words, each with a validity bit, a 64-bit comparand register, four 64-bit mask registers and a 32-bit status word. The status word counts the valid entries. A 32-bit access reaches one half of a 64-bit target, selected by the half-select pin.

The cycle is sequenced by a four-state machine:
- **IDLE**: waits for the strobe to go low, then captures the qualifiers and moves to EXEC.
- **EXEC**: commits writes to storage. It moves to DRIVE for a selected read, to RELEASE for any other cycle, or straight back to IDLE if the strobe is already high again.
- **DRIVE**: enables the read outputs while the strobe stays low. It returns to IDLE when the strobe goes high.
- **RELEASE**: holds the cycle without driving anything. It returns to IDLE when the strobe goes high.

Top module: `cam_host_if`

## Requirements
- R1: After reset all entries, validity bits, the comparand and the masks are zero. While `strobe_n` is high neither `data_oe` nor `valid_oe` is asserted. Two consecutive high samples of the strobe leave the machine in IDLE.
- R2: A cycle acts only when `sel_a_n` or `sel_b_n` is low at the falling edge. With both high, no storage changes and no output is enabled.
- R3: A selected cycle with `ctl_mode` low and `wr_n` low is a data write. It stores `data_in` into entry `cmd_addr[4:0]`. The target is bits 31..0 when `upper_half` is 0 and bits 63..32 when it is 1. The other half is unchanged.
- R4: On a data write, `valid_in_n` low marks the entry valid and `valid_in_n` high marks it empty.
- R5: A selected data read (`ctl_mode` low, `wr_n` high) drives the chosen half on `data_out` and the entry's inverted validity on `valid_out_n`. Both `data_oe` and `valid_oe` are asserted from the second clock after the falling edge until the strobe rises.
- R6: `data_oe` is asserted only during a selected read and only while the strobe is low. It drops in the same cycle in which the strobe rises.
- R7: Qualifier and data pins that change after the falling edge have no effect on the cycle in progress.
- R8: With `ctl_mode` high, `cmd_addr[3:0]` is a control code, and `upper_half` picks the half for every 64-bit target.
  - Code 1 writes or reads the comparand.
  - Code 2 writes or reads mask register `cmd_addr[5:4]`.
  - A control read drives `data_oe` but never `valid_oe`.
- R9: Control code 3 reads status. Bits 5..0 hold the number of valid entries and all other bits read zero. With `upper_half` high the read returns zero.
- R10: Control code 4 in a selected write cycle clears every validity bit and leaves entry data unchanged.
- R11: Any other control code ignores writes and reads as zero, with `data_oe` still asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strobe_n | input | 1 | Active-low cycle strobe |
| wr_n | input | 1 | Direction: low writes into the block, high reads out |
| sel_a_n | input | 1 | Active-low chip select A |
| sel_b_n | input | 1 | Active-low chip select B |
| ctl_mode | input | 1 | Low: `cmd_addr` is an entry address. High: it is a control code |
| cmd_addr | input | 6 | Entry address or control code (plus mask index) |
| upper_half | input | 1 | Selects bits 63..32 (1) or 31..0 (0) |
| valid_in_n | input | 1 | Validity for data writes, low = valid |
| data_in | input | 32 | Write data |
| data_out | output | 32 | Read data |
| data_oe | output | 1 | Enable for `data_out` |
| valid_out_n | output | 1 | Entry validity on data reads, low = valid |
| valid_oe | output | 1 | Enable for `valid_out_n` |

## Verification
On every cycle, the assertions check four things:
- the machine is back in IDLE after two high strobe samples;
- captured qualifiers stay frozen while the strobe stays low;
- the read enable appears only for a captured selected read;
- the storage effects of validity writes and clear-all happen, and a deselected EXEC leaves the validity bits untouched.

Three behaviours can only be shown by the bench's scenarios, because they depend on values written earlier through the same interface: that the correct half of the correct entry or register is returned, that the status word counts valid entries, and that unknown codes read as zero.

// File: rtl/cam_host_pkg.sv
package cam_host_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_EXEC,
        ST_DRIVE,
        ST_RELEASE
    } chi_state_e;

    localparam int CODE_W = 4;

    localparam logic [CODE_W-1:0] CTL_CMPND  = 4'd1;
    localparam logic [CODE_W-1:0] CTL_MASK   = 4'd2;
    localparam logic [CODE_W-1:0] CTL_STATUS = 4'd3;
    localparam logic [CODE_W-1:0] CTL_CLRVAL = 4'd4;

endpackage

// File: rtl/chi_capture.sv
module chi_capture #(
    parameter int AC_W   = 6,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              wr_n,
    input  logic              sel_a_n,
    input  logic              sel_b_n,
    input  logic              ctl_mode,
    input  logic [AC_W-1:0]   cmd_addr,
    input  logic              upper_half,
    input  logic              valid_in_n,
    input  logic [DATA_W-1:0] data_in,
    output logic              c_wr_n,
    output logic              c_sel,
    output logic              c_ctl,
    output logic [AC_W-1:0]   c_ac,
    output logic              c_upper,
    output logic              c_vb_n,
    output logic [DATA_W-1:0] c_data
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_wr_n  <= 1'b1;
            c_sel   <= 1'b0;
            c_ctl   <= 1'b0;
            c_ac    <= '0;
            c_upper <= 1'b0;
            c_vb_n  <= 1'b1;
            c_data  <= '0;
        end else if (load) begin
            c_wr_n  <= wr_n;
            c_sel   <= !sel_a_n || !sel_b_n;
            c_ctl   <= ctl_mode;
            c_ac    <= cmd_addr;
            c_upper <= upper_half;
            c_vb_n  <= valid_in_n;
            c_data  <= data_in;
        end
    end

endmodule

// File: rtl/chi_fsm.sv
module chi_fsm
    import cam_host_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_n,
    input  logic c_sel,
    input  logic c_wr_n,
    output logic load,
    output logic exec,
    output logic drive
);

    chi_state_e state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (!strobe_n) state_nx = ST_EXEC;
            end
            ST_EXEC: begin
                if (strobe_n)             state_nx = ST_IDLE;
                else if (c_sel && c_wr_n) state_nx = ST_DRIVE;
                else                      state_nx = ST_RELEASE;
            end
            ST_DRIVE: begin
                if (strobe_n) state_nx = ST_IDLE;
            end
            ST_RELEASE: begin
                if (strobe_n) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        load  = 1'b0;
        exec  = 1'b0;
        drive = 1'b0;
        unique case (state)
            ST_IDLE:    load  = !strobe_n;
            ST_EXEC:    exec  = 1'b1;
            ST_DRIVE:   drive = !strobe_n;
            ST_RELEASE: ;
            default:    ;
        endcase
    end

    // R1
    idle_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_n && $past(strobe_n)) |-> (state == ST_IDLE));

endmodule

// File: rtl/chi_store.sv
module chi_store
    import cam_host_pkg::*;
#(
    parameter int N_ENTRIES = 32,
    parameter int N_MASKS   = 4,
    parameter int AC_W      = 6,
    parameter int DATA_W    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exec,
    input  logic              c_sel,
    input  logic              c_wr_n,
    input  logic              c_ctl,
    input  logic [AC_W-1:0]   c_ac,
    input  logic              c_upper,
    input  logic              c_vb_n,
    input  logic [DATA_W-1:0] c_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_vb_n
);

    localparam int ADDR_W = $clog2(N_ENTRIES);
    localparam int MSEL_W = (N_MASKS > 1) ? $clog2(N_MASKS) : 1;
    localparam int CNT_W  = $clog2(N_ENTRIES + 1);
    localparam int WORD_W = 2 * DATA_W;

    logic [WORD_W-1:0]    ent     [N_ENTRIES];
    logic                 valid_q [N_ENTRIES];
    logic [N_ENTRIES-1:0] valid_vec;
    logic [WORD_W-1:0]    mask_q  [N_MASKS];
    logic [WORD_W-1:0]    cmpnd_q;

    logic [ADDR_W-1:0] addr;
    logic [MSEL_W-1:0] msel;
    logic [CODE_W-1:0] code;
    logic              wr_cyc, data_wr, ctl_wr, clr_all;
    logic [CNT_W-1:0]  vcount;

    assign addr    = c_ac[ADDR_W-1:0];
    assign code    = c_ac[CODE_W-1:0];
    assign msel    = c_ac[CODE_W +: MSEL_W];
    assign wr_cyc  = exec && c_sel && !c_wr_n;
    assign data_wr = wr_cyc && !c_ctl;
    assign ctl_wr  = wr_cyc && c_ctl;
    assign clr_all = ctl_wr && (code == CTL_CLRVAL);

    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_ent
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ent[g]     <= '0;
                valid_q[g] <= 1'b0;
            end else if (data_wr && (addr == ADDR_W'(g))) begin
                if (c_upper) ent[g][WORD_W-1:DATA_W] <= c_data;
                else         ent[g][DATA_W-1:0]      <= c_data;
                valid_q[g] <= !c_vb_n;
            end else if (clr_all) begin
                valid_q[g] <= 1'b0;
            end
        end
        assign valid_vec[g] = valid_q[g];
    end

    for (genvar m = 0; m < N_MASKS; m++) begin : g_mask
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mask_q[m] <= '0;
            end else if (ctl_wr && (code == CTL_MASK) && (msel == MSEL_W'(m))) begin
                if (c_upper) mask_q[m][WORD_W-1:DATA_W] <= c_data;
                else         mask_q[m][DATA_W-1:0]      <= c_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmpnd_q <= '0;
        end else if (ctl_wr && (code == CTL_CMPND)) begin
            if (c_upper) cmpnd_q[WORD_W-1:DATA_W] <= c_data;
            else         cmpnd_q[DATA_W-1:0]      <= c_data;
        end
    end

    always_comb begin
        vcount = '0;
        for (int i = 0; i < N_ENTRIES; i++) vcount = vcount + CNT_W'(valid_vec[i]);
    end

    always_comb begin
        rd_data = '0;
        rd_vb_n = 1'b1;
        if (!c_ctl) begin
            rd_data = c_upper ? ent[addr][WORD_W-1:DATA_W] : ent[addr][DATA_W-1:0];
            rd_vb_n = !valid_q[addr];
        end else begin
            case (code)
                CTL_CMPND:  rd_data = c_upper ? cmpnd_q[WORD_W-1:DATA_W] : cmpnd_q[DATA_W-1:0];
                CTL_MASK:   rd_data = c_upper ? mask_q[msel][WORD_W-1:DATA_W]
                                              : mask_q[msel][DATA_W-1:0];
                CTL_STATUS: rd_data = c_upper ? '0 : DATA_W'(vcount);
                default:    rd_data = '0;
            endcase
        end
    end

    // R2
    unselected_keeps_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && !c_sel) |=> $stable(valid_vec));

    // R4
    valid_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && c_sel && !c_wr_n && !c_ctl) |=> (valid_vec[addr] == !c_vb_n));

    // R10
    clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && c_sel && !c_wr_n && c_ctl && code == CTL_CLRVAL) |=> (valid_vec == '0));

endmodule

// File: rtl/cam_host_if.sv
module cam_host_if #(
    parameter int N_ENTRIES = 32,
    parameter int N_MASKS   = 4,
    parameter int AC_W      = 6,
    parameter int DATA_W    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe_n,
    input  logic              wr_n,
    input  logic              sel_a_n,
    input  logic              sel_b_n,
    input  logic              ctl_mode,
    input  logic [AC_W-1:0]   cmd_addr,
    input  logic              upper_half,
    input  logic              valid_in_n,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe,
    output logic              valid_out_n,
    output logic              valid_oe
);

    logic              load, exec, drive;
    logic              c_wr_n, c_sel, c_ctl, c_upper, c_vb_n;
    logic [AC_W-1:0]   c_ac;
    logic [DATA_W-1:0] c_data;
    logic [DATA_W-1:0] rd_data;
    logic              rd_vb_n;

    chi_capture #(.AC_W(AC_W), .DATA_W(DATA_W)) u_capture (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .wr_n       (wr_n),
        .sel_a_n    (sel_a_n),
        .sel_b_n    (sel_b_n),
        .ctl_mode   (ctl_mode),
        .cmd_addr   (cmd_addr),
        .upper_half (upper_half),
        .valid_in_n (valid_in_n),
        .data_in    (data_in),
        .c_wr_n     (c_wr_n),
        .c_sel      (c_sel),
        .c_ctl      (c_ctl),
        .c_ac       (c_ac),
        .c_upper    (c_upper),
        .c_vb_n     (c_vb_n),
        .c_data     (c_data)
    );

    chi_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_n (strobe_n),
        .c_sel    (c_sel),
        .c_wr_n   (c_wr_n),
        .load     (load),
        .exec     (exec),
        .drive    (drive)
    );

    chi_store #(
        .N_ENTRIES (N_ENTRIES),
        .N_MASKS   (N_MASKS),
        .AC_W      (AC_W),
        .DATA_W    (DATA_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .exec    (exec),
        .c_sel   (c_sel),
        .c_wr_n  (c_wr_n),
        .c_ctl   (c_ctl),
        .c_ac    (c_ac),
        .c_upper (c_upper),
        .c_vb_n  (c_vb_n),
        .c_data  (c_data),
        .rd_data (rd_data),
        .rd_vb_n (rd_vb_n)
    );

    assign data_oe     = drive;
    assign valid_oe    = drive && !c_ctl;
    assign data_out    = drive ? rd_data : '0;
    assign valid_out_n = valid_oe ? rd_vb_n : 1'b1;

    // R6
    oe_read_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> (c_sel && c_wr_n && !strobe_n));

    // R7
    capture_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe_n && $past(!strobe_n) && $past(!strobe_n, 2))
            |-> ($stable(c_data) && $stable(c_ac) && $stable(c_wr_n) && $stable(c_upper)));

    // R5
    valid_oe_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_oe |-> (data_oe && !c_ctl));

endmodule

// File: tb/test_cam_host_if.sv
module test_cam_host_if;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strobe_n = 1'b1;
    logic        wr_n = 1'b1;
    logic        sel_a_n = 1'b1;
    logic        sel_b_n = 1'b1;
    logic        ctl_mode = 1'b0;
    logic [5:0]  cmd_addr = '0;
    logic        upper_half = 1'b0;
    logic        valid_in_n = 1'b1;
    logic [31:0] data_in = '0;
    logic [31:0] data_out;
    logic        data_oe;
    logic        valid_out_n;
    logic        valid_oe;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [63:0] m_mem  [32];
    bit          m_val  [32];
    logic [63:0] m_mask [4];
    logic [63:0] m_cmp;

    always #10 clk = ~clk;

    cam_host_if i_cam_host_if (
        .clk         (clk),
        .rst_n       (rst_n),
        .strobe_n    (strobe_n),
        .wr_n        (wr_n),
        .sel_a_n     (sel_a_n),
        .sel_b_n     (sel_b_n),
        .ctl_mode    (ctl_mode),
        .cmd_addr    (cmd_addr),
        .upper_half  (upper_half),
        .valid_in_n  (valid_in_n),
        .data_in     (data_in),
        .data_out    (data_out),
        .data_oe     (data_oe),
        .valid_out_n (valid_out_n),
        .valid_oe    (valid_oe)
    );

    task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    function automatic int vcount();
        int c = 0;
        for (int i = 0; i < 32; i++) c += int'(m_val[i]);
        return c;
    endfunction

    task automatic access(input bit w_n, input bit sa_n, input bit sb_n, input bit ctl,
                          input logic [5:0] ac, input bit up, input bit vb_n,
                          input logic [31:0] d, input bit scramble, input string rq);
        bit          sel = !sa_n || !sb_n;
        bit          rd  = sel && w_n;
        logic [31:0] exp_d = '0;
        bit          exp_vb_n = 1'b1;
        logic [3:0]  code = ac[3:0];
        if (!ctl) begin
            exp_d    = up ? m_mem[ac[4:0]][63:32] : m_mem[ac[4:0]][31:0];
            exp_vb_n = !m_val[ac[4:0]];
        end else if (code == 4'd1) exp_d = up ? m_cmp[63:32] : m_cmp[31:0];
        else if (code == 4'd2)      exp_d = up ? m_mask[ac[5:4]][63:32] : m_mask[ac[5:4]][31:0];
        else if (code == 4'd3)      exp_d = up ? 32'd0 : 32'(vcount());
        @(negedge clk);
        wr_n = w_n; sel_a_n = sa_n; sel_b_n = sb_n; ctl_mode = ctl; cmd_addr = ac;
        upper_half = up; valid_in_n = vb_n; data_in = d; strobe_n = 1'b0;
        @(negedge clk);
        chk(data_oe == 1'b0, {rq, " oe low in first strobe cycle"}, 64'(data_oe), 64'd0);
        if (scramble) begin
            wr_n = !w_n; cmd_addr = ac ^ 6'h1f; upper_half = !up; valid_in_n = !vb_n;
            data_in = ~d; sel_a_n = 1'b1; sel_b_n = 1'b1; ctl_mode = !ctl;
        end
        @(negedge clk);
        if (rd) begin
            chk(data_oe == 1'b1, {rq, " read oe"}, 64'(data_oe), 64'd1);
            chk(data_out == exp_d, {rq, " read data"}, 64'(data_out), 64'(exp_d));
            chk(valid_oe == !ctl, {rq, " validity oe"}, 64'(valid_oe), 64'(!ctl));
            if (!ctl) chk(valid_out_n == exp_vb_n, {rq, " validity value"},
                          64'(valid_out_n), 64'(exp_vb_n));
        end else begin
            chk(data_oe == 1'b0 && valid_oe == 1'b0, {rq, " no drive on non-read"},
                64'({data_oe, valid_oe}), 64'd0);
        end
        strobe_n = 1'b1;
        #1;
        // R6: enable drops in the cycle the strobe rises
        chk(data_oe == 1'b0, "R6 oe released with strobe", 64'(data_oe), 64'd0);
        if (sel && !w_n) begin
            if (!ctl) begin
                if (up) m_mem[ac[4:0]][63:32] = d; else m_mem[ac[4:0]][31:0] = d;
                m_val[ac[4:0]] = !vb_n;
            end else if (code == 4'd1) begin
                if (up) m_cmp[63:32] = d; else m_cmp[31:0] = d;
            end else if (code == 4'd2) begin
                if (up) m_mask[ac[5:4]][63:32] = d; else m_mask[ac[5:4]][31:0] = d;
            end else if (code == 4'd4) begin
                for (int i = 0; i < 32; i++) m_val[i] = 1'b0;
            end
        end
        @(negedge clk);
        chk(data_oe == 1'b0 && valid_oe == 1'b0, "R1 idle between cycles",
            64'({data_oe, valid_oe}), 64'd0);
    endtask

    task automatic dwrite(input logic [4:0] a, input bit up, input bit vb_n, input logic [31:0] d,
                          input string rq);
        access(1'b0, 1'b0, 1'b1, 1'b0, {1'b0, a}, up, vb_n, d, 1'b0, rq);
    endtask

    task automatic dread(input logic [4:0] a, input bit up, input string rq);
        access(1'b1, 1'b1, 1'b0, 1'b0, {1'b0, a}, up, 1'b1, 32'h0, 1'b0, rq);
    endtask

    task automatic cwrite(input logic [5:0] ac, input bit up, input logic [31:0] d, input string rq);
        access(1'b0, 1'b0, 1'b0, 1'b1, ac, up, 1'b1, d, 1'b0, rq);
    endtask

    task automatic cread(input logic [5:0] ac, input bit up, input string rq);
        access(1'b1, 1'b0, 1'b1, 1'b1, ac, up, 1'b1, 32'h0, 1'b0, rq);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) begin m_mem[i] = '0; m_val[i] = 1'b0; end
        for (int i = 0; i < 4; i++) m_mask[i] = '0;
        m_cmp = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state with strobe high
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(data_oe == 1'b0 && valid_oe == 1'b0 && data_out == 32'd0, "R1 reset idle",
                64'({data_oe, valid_oe, data_out}), 64'd0);
        end
        dread(5'd9, 1'b0, "R1 entry zero after reset");
        cread(6'h03, 1'b0, "R9 status zero after reset");
        // R3/R4/R5: both halves of an entry
        dwrite(5'd5, 1'b0, 1'b0, 32'hDEAD_BEEF, "R3 low half write");
        dwrite(5'd5, 1'b1, 1'b0, 32'h1234_5678, "R3 high half write");
        dread(5'd5, 1'b0, "R5 low half read");
        dread(5'd5, 1'b1, "R5 high half read");
        // R4: empty on write with validity pin high
        dwrite(5'd31, 1'b0, 1'b1, 32'hA5A5_0001, "R4 write marks empty");
        dread(5'd31, 1'b0, "R4 empty entry reads validity high");
        // R2: deselected write ignored
        access(1'b0, 1'b1, 1'b1, 1'b0, 6'd5, 1'b0, 1'b0, 32'h0BAD_0BAD, 1'b0, "R2 deselected write");
        dread(5'd5, 1'b0, "R2 entry unchanged");
        access(1'b1, 1'b1, 1'b1, 1'b0, 6'd5, 1'b0, 1'b1, 32'h0, 1'b0, "R2 deselected read");
        // R7: pins scrambled after the falling edge
        access(1'b0, 1'b0, 1'b1, 1'b0, 6'd7, 1'b1, 1'b0, 32'hCAFE_F00D, 1'b1, "R7 scrambled write");
        dread(5'd7, 1'b1, "R7 captured value stored");
        dread(5'd7, 1'b0, "R7 other half untouched");
        dread(5'd24, 1'b1, "R7 scrambled address untouched");
        access(1'b1, 1'b1, 1'b0, 1'b0, 6'd5, 1'b1, 1'b1, 32'h0, 1'b1, "R7 scrambled read");
        // R8: comparand and masks
        cwrite(6'h01, 1'b0, 32'h1111_2222, "R8 comparand low");
        cwrite(6'h01, 1'b1, 32'h3333_4444, "R8 comparand high");
        cread(6'h01, 1'b0, "R8 comparand low read");
        cread(6'h01, 1'b1, "R8 comparand high read");
        cwrite(6'h32, 1'b1, 32'hF0F0_0F0F, "R8 mask 3 high");
        cread(6'h32, 1'b1, "R8 mask 3 high read");
        cread(6'h32, 1'b0, "R8 mask 3 low read");
        cread(6'h02, 1'b1, "R8 mask 0 unaffected");
        // R9: status count
        cread(6'h03, 1'b0, "R9 status count");
        cread(6'h03, 1'b1, "R9 status upper half zero");
        // R11: unknown code
        cwrite(6'h09, 1'b0, 32'hFFFF_FFFF, "R11 unknown code write");
        cread(6'h09, 1'b0, "R11 unknown code reads zero");
        cread(6'h01, 1'b0, "R11 comparand unaffected");
        // patterns across the whole array
        for (int i = 0; i < 32; i++)
            dwrite(5'(i), i[0], i[1], 32'h0101_0101 * (i + 1), "R3 sweep write");
        for (int i = 0; i < 32; i++) dread(5'(i), i[0], "R5 sweep read");
        cread(6'h03, 1'b0, "R9 status after sweep");
        // R10: clear validity
        cwrite(6'h04, 1'b0, 32'h0, "R10 clear validity");
        dread(5'd6, 1'b0, "R10 data kept, entry empty");
        cread(6'h03, 1'b0, "R10 status zero after clear");
        access(1'b1, 1'b0, 1'b1, 1'b1, 6'h04, 1'b0, 1'b1, 32'h0, 1'b0, "R10 read of clear code");
        dwrite(5'd2, 1'b0, 1'b0, 32'h7777_7777, "R4 revalidate");
        cread(6'h03, 1'b0, "R9 status one valid");
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule